// File: doc/BRIEF.md
# Banked Real-Time Clock with Snapshot Latch

This block is the timekeeping half of a cartridge-style bank mapper. It keeps a seconds, minutes and hours count and a 9-bit day count. A divider advances them once per second of a base-rate tick-enable input. The host reaches the block over the same byte-wide address, data and strobe bus that drives the mapper. One address range loads a 7-bit ROM bank number. A second range chooses what the 8 KiB external window at 0xA000–0xBFFF shows: either a RAM bank (the RAM array itself lives outside the block) or one of five clock registers.

A third address range carries a snapshot command. Writing 0 and then 1 there copies all five clock registers into a shadow set. While the last value written to that range is non-zero, window reads of a clock register return the frozen shadow copy, so software reads a coherent time stamp while the live counters keep running. Window writes always go to the live counters. The flags register holds the ninth day bit, a halt control and a sticky day-overflow flag.

Top module: `banked_rtc`

## Requirements
- R1: A write whose address bits 15:13 equal 3'b001 loads the ROM bank from data bits 6:0. A loaded value of 0 becomes 1. The ROM bank reads 1 after reset.
- R2: A write whose address bits 15:13 equal 3'b010 with data 0x08 to 0x0C maps the window onto clock register (data − 0x08) and leaves the RAM bank unchanged. Any other data unmaps the clock and sets the RAM bank to data bits 1:0. `ram_cs_o` is high exactly during a read or write strobe to the window while no clock register is mapped.
- R3: Clock register index 0 is seconds, 1 minutes, 2 hours, 3 day bits 7:0. Index 4 is flags: bit 0 is day bit 8, bit 6 is halt, bit 7 is the overflow flag, and the other bits read 0. Seconds and minutes read in bits 5:0 and hours in bits 4:0, with upper bits 0.
- R4: While halt is clear, the counters advance by one second on every TICKS_PER_SEC-th cycle with `tick_i` high.
- R5: Seconds and minutes wrap from 59 to 0, and hours from 23 to 0. Each wrap carries one count into the next field.
- R6: The day count is 9 bits wide. An advance from 511 gives 0 and sets the overflow flag.
- R7: The overflow flag stays set through further counting. Only a flags write with bit 7 = 0 clears it.
- R8: While halt is set, neither the tick divider nor any counter moves.
- R9: A seconds write also clears the tick divider, so the next advance comes a full TICKS_PER_SEC ticks later.
- R10: A write to the range with address bits 15:13 = 3'b011 takes a snapshot only when its data is 0x01 and the previous value written there was 0x00. Window reads of a clock register return the snapshot while the last value written there is non-zero, and the live value while it is zero (the state after reset).
- R11: A window write while a clock register is mapped updates the live register even during a snapshot, and leaves the snapshot unchanged.
- R12: After reset all counters, halt, the overflow flag and `rdata_o` are 0, and the RAM bank is 0 with no clock register mapped.
- R13: `rdata_o` takes the addressed clock register value on the clock edge that samples a window read strobe with a clock register mapped. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Base-rate tick enable, TICKS_PER_SEC per second |
| wr_en_i | input | 1 | Bus write strobe, one cycle per access |
| rd_en_i | input | 1 | Bus read strobe, one cycle per access |
| addr_i | input | 16 | Bus address |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Clock register read data, registered |
| rom_bank_o | output | ROM_BANK_W | Selected switchable ROM bank |
| ram_bank_o | output | RAM_BANK_W | Selected external RAM bank |
| ram_cs_o | output | 1 | Window access is routed to external RAM |

## Verification
The checks assume that read and write strobes are never high in the same cycle. They also assume that software loads time fields only with in-range values (seconds and minutes below 60, hours below 24), because the wrap rules compare against those limits. The stimulus issues one bus access per task call. It draws time values from those ranges and keeps `tick_i` low during bus cycles, so a write never lands on a second boundary. Halt and the overflow flag are set at random through flag writes, so that frozen and sticky states are mixed into the random runs.

// File: rtl/banked_rtc_pkg.sv
package banked_rtc_pkg;

  localparam int SEC_W        = 6;
  localparam int MIN_W        = 6;
  localparam int HR_W         = 5;
  localparam int DAY_W        = 9;
  localparam int NUM_CLK_REGS = 5;
  localparam int SEC_LIMIT    = 59;
  localparam int MIN_LIMIT    = 59;
  localparam int HR_LIMIT     = 23;

  localparam logic [2:0] REGION_ROMSEL  = 3'b001;
  localparam logic [2:0] REGION_BANKSEL = 3'b010;
  localparam logic [2:0] REGION_LATCH   = 3'b011;
  localparam logic [2:0] REGION_WINDOW  = 3'b101;

  localparam logic [7:0] CLK_SEL_FIRST = 8'h08;
  localparam logic [7:0] CLK_SEL_LAST  = 8'h0C;

  typedef enum logic [2:0] {
    CR_SEC   = 3'd0,
    CR_MIN   = 3'd1,
    CR_HR    = 3'd2,
    CR_DAYLO = 3'd3,
    CR_FLAGS = 3'd4
  } clk_reg_e;

  typedef struct packed {
    logic             carry;
    logic             halt;
    logic [DAY_W-1:0] day;
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] min;
    logic [SEC_W-1:0] sec;
  } rtc_time_t;

  function automatic logic [7:0] reg_view(input rtc_time_t t, input clk_reg_e idx);
    logic [7:0] v;
    case (idx)
      CR_SEC:   v = 8'(t.sec);
      CR_MIN:   v = 8'(t.min);
      CR_HR:    v = 8'(t.hr);
      CR_DAYLO: v = t.day[7:0];
      CR_FLAGS: v = {t.carry, t.halt, 5'b00000, t.day[DAY_W-1]};
      default:  v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/rtc_bank_decode.sv
module rtc_bank_decode
  import banked_rtc_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [15:0]           addr_i,
  input  logic [7:0]            wdata_i,
  output logic [ROM_BANK_W-1:0] rom_bank_o,
  output logic [RAM_BANK_W-1:0] ram_bank_o,
  output logic                  clk_sel_o,
  output clk_reg_e              clk_idx_o,
  output logic                  latch_evt_o,
  output logic                  latched_o,
  output logic                  clk_wr_o,
  output logic                  clk_rd_o,
  output logic                  ram_cs_o
);

  logic [2:0] region;
  logic       unused_addr_low;

  logic [ROM_BANK_W-1:0] rom_q, rom_d;
  logic [RAM_BANK_W-1:0] ram_q, ram_d;
  logic                  sel_q, sel_d;
  clk_reg_e              idx_q, idx_d;
  logic                  zero_q, zero_d;

  logic                  wr_rom, wr_bank, wr_latch, win_hit;
  logic [ROM_BANK_W-1:0] rom_raw;
  logic [7:0]            sel_off;

  assign region          = addr_i[15:13];
  assign unused_addr_low = ^addr_i[12:0];

  assign wr_rom   = wr_en_i && (region == REGION_ROMSEL);
  assign wr_bank  = wr_en_i && (region == REGION_BANKSEL);
  assign wr_latch = wr_en_i && (region == REGION_LATCH);
  assign win_hit  = region == REGION_WINDOW;
  assign rom_raw  = wdata_i[ROM_BANK_W-1:0];
  assign sel_off  = wdata_i - CLK_SEL_FIRST;

  always_comb begin
    rom_d  = rom_q;
    ram_d  = ram_q;
    sel_d  = sel_q;
    idx_d  = idx_q;
    zero_d = zero_q;
    if (wr_rom) begin
      rom_d = (rom_raw == '0) ? ROM_BANK_W'(1) : rom_raw;
    end
    if (wr_bank) begin
      if ((wdata_i >= CLK_SEL_FIRST) && (wdata_i <= CLK_SEL_LAST)) begin
        sel_d = 1'b1;
        idx_d = clk_reg_e'(sel_off[2:0]);
      end else begin
        sel_d = 1'b0;
        ram_d = wdata_i[RAM_BANK_W-1:0];
      end
    end
    if (wr_latch) begin
      zero_d = (wdata_i == 8'h00);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_q  <= ROM_BANK_W'(1);
      ram_q  <= '0;
      sel_q  <= 1'b0;
      idx_q  <= CR_SEC;
      zero_q <= 1'b1;
    end else begin
      rom_q  <= rom_d;
      ram_q  <= ram_d;
      sel_q  <= sel_d;
      idx_q  <= idx_d;
      zero_q <= zero_d;
    end
  end

  assign rom_bank_o  = rom_q;
  assign ram_bank_o  = ram_q;
  assign clk_sel_o   = sel_q;
  assign clk_idx_o   = idx_q;
  assign latch_evt_o = wr_latch && zero_q && (wdata_i == 8'h01);
  assign latched_o   = !zero_q;
  assign clk_wr_o    = wr_en_i && win_hit && sel_q;
  assign clk_rd_o    = rd_en_i && win_hit && sel_q;
  assign ram_cs_o    = (wr_en_i || rd_en_i) && win_hit && !sel_q;

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic run_i,
  input  logic clr_i,
  output logic sec_pulse_o
);

  localparam int CNT_W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step_en;

  assign step_en     = run_i && tick_i;
  assign sec_pulse_o = step_en && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)            cnt_d = '0;
    else if (sec_pulse_o) cnt_d = '0;
    else if (step_en)     cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import banked_rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sec_pulse_i,
  input  logic      wr_i,
  input  clk_reg_e  idx_i,
  input  logic [7:0] wdata_i,
  output rtc_time_t time_o
);

  rtc_time_t cur_q, nxt;
  logic      c_min, c_hr, c_day;

  always_comb begin
    nxt   = cur_q;
    c_min = 1'b0;
    c_hr  = 1'b0;
    c_day = 1'b0;
    if (sec_pulse_i) begin
      if (cur_q.sec == SEC_W'(SEC_LIMIT)) begin
        nxt.sec = '0;
        c_min   = 1'b1;
      end else begin
        nxt.sec = cur_q.sec + SEC_W'(1);
      end
      if (c_min) begin
        if (cur_q.min == MIN_W'(MIN_LIMIT)) begin
          nxt.min = '0;
          c_hr    = 1'b1;
        end else begin
          nxt.min = cur_q.min + MIN_W'(1);
        end
      end
      if (c_hr) begin
        if (cur_q.hr == HR_W'(HR_LIMIT)) begin
          nxt.hr = '0;
          c_day  = 1'b1;
        end else begin
          nxt.hr = cur_q.hr + HR_W'(1);
        end
      end
      if (c_day) begin
        if (cur_q.day == '1) begin
          nxt.day   = '0;
          nxt.carry = 1'b1;
        end else begin
          nxt.day = cur_q.day + DAY_W'(1);
        end
      end
    end
    if (wr_i) begin
      case (idx_i)
        CR_SEC:   nxt.sec = wdata_i[SEC_W-1:0];
        CR_MIN:   nxt.min = wdata_i[MIN_W-1:0];
        CR_HR:    nxt.hr  = wdata_i[HR_W-1:0];
        CR_DAYLO: nxt.day[7:0] = wdata_i;
        CR_FLAGS: begin
          nxt.day[DAY_W-1] = wdata_i[0];
          nxt.halt         = wdata_i[6];
          nxt.carry        = wdata_i[7];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= nxt;
  end

  assign time_o = cur_q;

endmodule

// File: rtl/banked_rtc.sv
module banked_rtc
  import banked_rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ROM_BANK_W    = 7,
  parameter int RAM_BANK_W    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [15:0]           addr_i,
  input  logic [7:0]            wdata_i,
  output logic [7:0]            rdata_o,
  output logic [ROM_BANK_W-1:0] rom_bank_o,
  output logic [RAM_BANK_W-1:0] ram_bank_o,
  output logic                  ram_cs_o
);

  localparam int SHADOW_W = NUM_CLK_REGS * 8;

  logic          rst_sn;
  logic          clk_sel, latch_evt, latched, clk_wr, clk_rd;
  clk_reg_e      clk_idx;
  logic          sec_pulse, clr_div;
  rtc_time_t     live;
  logic [SHADOW_W-1:0] shadow_flat;
  logic [7:0]    rdata_q, rdata_d, sel_view;

  rtc_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  rtc_bank_decode #(
    .ROM_BANK_W (ROM_BANK_W),
    .RAM_BANK_W (RAM_BANK_W)
  ) u_dec (
    .clk         (clk),
    .rst_n       (rst_sn),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rom_bank_o  (rom_bank_o),
    .ram_bank_o  (ram_bank_o),
    .clk_sel_o   (clk_sel),
    .clk_idx_o   (clk_idx),
    .latch_evt_o (latch_evt),
    .latched_o   (latched),
    .clk_wr_o    (clk_wr),
    .clk_rd_o    (clk_rd),
    .ram_cs_o    (ram_cs_o)
  );

  assign clr_div = clk_wr && (clk_idx == CR_SEC);

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
    .clk         (clk),
    .rst_n       (rst_sn),
    .tick_i      (tick_i),
    .run_i       (!live.halt),
    .clr_i       (clr_div),
    .sec_pulse_o (sec_pulse)
  );

  rtc_timekeeper u_time (
    .clk         (clk),
    .rst_n       (rst_sn),
    .sec_pulse_i (sec_pulse),
    .wr_i        (clk_wr),
    .idx_i       (clk_idx),
    .wdata_i     (wdata_i),
    .time_o      (live)
  );

  for (genvar g = 0; g < NUM_CLK_REGS; g++) begin : g_shadow
    logic [7:0] snap_q;
    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn)        snap_q <= '0;
      else if (latch_evt) snap_q <= reg_view(live, clk_reg_e'(g));
    end
    assign shadow_flat[g*8 +: 8] = snap_q;
  end

  assign sel_view = latched ? shadow_flat[clk_idx*8 +: 8] : reg_view(live, clk_idx);

  always_comb begin
    rdata_d = rdata_q;
    if (clk_rd) rdata_d = sel_view;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/banked_rtc_chk.sv
module banked_rtc_chk
  import banked_rtc_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int SHADOW_W   = 40
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en_i,
  input logic [15:0]           addr_i,
  input logic [7:0]            wdata_i,
  input logic [ROM_BANK_W-1:0] rom_bank_o,
  input logic                  ram_cs_o,
  input logic                  clk_sel,
  input logic                  clk_wr,
  input logic                  clk_rd,
  input clk_reg_e              clk_idx,
  input logic                  sec_pulse,
  input rtc_time_t             live,
  input logic                  latch_evt,
  input logic [SHADOW_W-1:0]   shadow_flat,
  input logic [7:0]            rdata_o
);

  assert_rom_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rom_bank_o != '0);

  assert_rom_zero_to_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i[15:13] == REGION_ROMSEL && wdata_i[ROM_BANK_W-1:0] == '0)
    |=> rom_bank_o == ROM_BANK_W'(1));

  assert_ramcs_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs_o |-> !clk_sel);

  assert_sec_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && live.sec == SEC_W'(SEC_LIMIT) && !clk_wr) |=> live.sec == '0);

  assert_day_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !clk_wr && live.sec == SEC_W'(SEC_LIMIT) && live.min == MIN_W'(MIN_LIMIT)
     && live.hr == HR_W'(HR_LIMIT) && live.day == '1)
    |=> (live.day == '0 && live.carry));

  assert_carry_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live.carry && !(clk_wr && clk_idx == CR_FLAGS)) |=> live.carry);

  assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (live.halt && !clk_wr) |=> $stable(live));

  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_evt |=> $stable(shadow_flat));

  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_rd |=> $stable(rdata_o));

endmodule

bind banked_rtc banked_rtc_chk #(
  .ROM_BANK_W (ROM_BANK_W),
  .SHADOW_W   (SHADOW_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sn),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rom_bank_o  (rom_bank_o),
  .ram_cs_o    (ram_cs_o),
  .clk_sel     (clk_sel),
  .clk_wr      (clk_wr),
  .clk_rd      (clk_rd),
  .clk_idx     (clk_idx),
  .sec_pulse   (sec_pulse),
  .live        (live),
  .latch_evt   (latch_evt),
  .shadow_flat (shadow_flat),
  .rdata_o     (rdata_o)
);

// File: tb/banked_rtc_tb.sv
`timescale 1ns/1ps
module banked_rtc_tb;

  localparam int TPS = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i, wr_en_i, rd_en_i;
  logic [15:0] addr_i;
  logic [7:0]  wdata_i;
  logic [7:0]  rdata_o;
  logic [6:0]  rom_bank_o;
  logic [1:0]  ram_bank_o;
  logic        ram_cs_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model state
  int m_sec, m_min, m_hr, m_day, m_halt, m_carry, m_pre;
  int m_rom, m_ram, m_csel, m_idx, m_zero, m_rd;
  int m_sh[5];

  always #2 clk = ~clk;

  banked_rtc #(.TICKS_PER_SEC(TPS)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .rom_bank_o (rom_bank_o),
    .ram_bank_o (ram_bank_o),
    .ram_cs_o   (ram_cs_o)
  );

  function automatic int mview(input int i);
    case (i)
      0: return m_sec;
      1: return m_min;
      2: return m_hr;
      3: return m_day & 255;
      4: return (m_carry << 7) | (m_halt << 6) | ((m_day >> 8) & 1);
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_second();
    if (m_sec == 59) begin
      m_sec = 0;
      if (m_min == 59) begin
        m_min = 0;
        if (m_hr == 23) begin
          m_hr = 0;
          if (m_day == 511) begin m_day = 0; m_carry = 1; end
          else m_day++;
        end else m_hr++;
      end else m_min++;
    end else m_sec++;
  endtask

  task automatic bus_wr(input logic [15:0] a, input int d);
    addr_i  = a;
    wdata_i = 8'(d);
    wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
    case (a[15:13])
      3'b001: m_rom = ((d & 127) == 0) ? 1 : (d & 127);
      3'b010: if (d >= 8 && d <= 12) begin m_csel = 1; m_idx = d - 8; end
              else begin m_csel = 0; m_ram = d & 3; end
      3'b011: begin
        if (m_zero == 1 && d == 1)
          for (int i = 0; i < 5; i++) m_sh[i] = mview(i);
        m_zero = (d == 0) ? 1 : 0;
      end
      3'b101: if (m_csel == 1) begin
        case (m_idx)
          0: begin m_sec = d & 63; m_pre = 0; end
          1: m_min = d & 63;
          2: m_hr  = d & 31;
          3: m_day = (m_day & 256) | (d & 255);
          default: begin
            m_day   = (m_day & 255) | ((d & 1) << 8);
            m_halt  = (d >> 6) & 1;
            m_carry = (d >> 7) & 1;
          end
        endcase
      end
      default: ;
    endcase
  endtask

  task automatic sel(input int d);
    bus_wr(16'h4000, d);
  endtask

  task automatic win_wr(input int d);
    bus_wr(16'hA000 | 16'($urandom & 32'h1FFF), d);
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (m_halt == 0) begin
        if (m_pre == TPS - 1) begin m_pre = 0; model_second(); end
        else m_pre++;
      end
    end
    tick_i = 1'b0;
  endtask

  task automatic rd_chk(input string tag);
    int exp;
    exp = (m_zero == 1) ? mview(m_idx) : m_sh[m_idx];
    addr_i  = 16'hA000 | 16'($urandom & 32'h1FFF);
    rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
    m_rd = exp;
    chk(tag, int'(rdata_o), exp);
  endtask

  task automatic read_reg(input int idx, input string tag);
    sel(8 + idx);
    rd_chk(tag);
  endtask

  task automatic ramcs_probe(input string tag);
    addr_i  = 16'hA000 | 16'($urandom & 32'h1FFF);
    rd_en_i = 1'b1;
    #1;
    chk(tag, int'(ram_cs_o), (m_csel == 0) ? 1 : 0);
    @(negedge clk);
    rd_en_i = 1'b0;
    chk({tag, " rdata hold R13"}, int'(rdata_o), m_rd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int d, op;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0; rd_en_i = 1'b0;
    addr_i = 16'h0000; wdata_i = 8'h00;
    m_sec = 0; m_min = 0; m_hr = 0; m_day = 0; m_halt = 0; m_carry = 0; m_pre = 0;
    m_rom = 1; m_ram = 0; m_csel = 0; m_idx = 0; m_zero = 1; m_rd = 0;
    for (int i = 0; i < 5; i++) m_sh[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    chk("R12 rdata after reset", int'(rdata_o), 0);
    chk("R1 rom bank after reset", int'(rom_bank_o), 1);
    chk("R12 ram bank after reset", int'(ram_bank_o), 0);
    ramcs_probe("R12 no clock mapped after reset");
    for (int i = 0; i < 5; i++) read_reg(i, "R12 clock register after reset");

    // ROM bank select
    bus_wr(16'h2000, 8'h00); chk("R1 zero becomes one", int'(rom_bank_o), 1);
    bus_wr(16'h3FFF, 8'h85); chk("R1 bit 7 ignored", int'(rom_bank_o), 5);
    bus_wr(16'h2ABC, 8'h80); chk("R1 masked zero becomes one", int'(rom_bank_o), 1);
    bus_wr(16'h2001, 8'h7F); chk("R1 full bank", int'(rom_bank_o), 127);

    // bank / clock select
    sel(8'h05); chk("R2 ram bank", int'(ram_bank_o), 1); ramcs_probe("R2 ram mapped");
    sel(8'h0D); chk("R2 just past clock range", int'(ram_bank_o), 1);
    sel(8'h07); chk("R2 ram bank 3", int'(ram_bank_o), 3);
    sel(8'h0C); chk("R2 clock keeps ram bank", int'(ram_bank_o), 3);
    ramcs_probe("R2 clock mapped");

    // load time near full wrap
    sel(8'h09); win_wr(59);
    sel(8'h0A); win_wr(23);
    sel(8'h0B); win_wr(8'hFF);
    sel(8'h0C); win_wr(8'h01);
    sel(8'h08); win_wr(58);
    for (int i = 0; i < 5; i++) read_reg(i, "R3 register readback R11");
    ticks(TPS - 1); read_reg(0, "R4 no advance before divider end");
    ticks(1);       read_reg(0, "R4 advance at divider end");
    ticks(TPS);
    for (int i = 0; i < 5; i++) read_reg(i, "R5 R6 full wrap with overflow");
    ticks(3 * TPS); read_reg(4, "R7 overflow stays set");
    sel(8'h0C); win_wr(8'h00); read_reg(4, "R7 overflow cleared");

    // halt
    sel(8'h0C); win_wr(8'h40);
    ticks(3 * TPS + 1); read_reg(0, "R8 halted seconds");
    sel(8'h0C); win_wr(8'h00);
    ticks(TPS); read_reg(0, "R8 resume after halt");

    // seconds write clears divider
    ticks(TPS - 1);
    sel(8'h08); win_wr(10);
    ticks(TPS - 1); read_reg(0, "R9 divider restarted");
    ticks(1);       read_reg(0, "R9 full second after write");

    // snapshot
    bus_wr(16'h6000, 0); bus_wr(16'h6000, 1);
    ticks(2 * TPS); read_reg(0, "R10 snapshot value");
    bus_wr(16'h7FFF, 1); ticks(TPS); read_reg(0, "R10 repeated one does not relatch");
    bus_wr(16'h6000, 2); read_reg(0, "R10 other value keeps snapshot");
    sel(8'h09); win_wr(33); read_reg(1, "R11 write during snapshot not visible");
    bus_wr(16'h6000, 0); read_reg(1, "R11 live written value");
    read_reg(0, "R10 live after release");
    bus_wr(16'h6000, 1); ticks(TPS); read_reg(0, "R10 new snapshot");
    bus_wr(16'h6000, 0);

    // constrained random
    for (int it = 0; it < 400; it++) begin
      op = $urandom_range(0, 7);
      case (op)
        0: begin
          bus_wr(16'h2000 | 16'($urandom & 32'h1FFF), $urandom_range(0, 255));
          chk("R1 random bank", int'(rom_bank_o), m_rom);
        end
        1: begin
          d = ($urandom_range(0, 3) != 0) ? 8 + $urandom_range(0, 4) : $urandom_range(0, 255);
          bus_wr(16'h4000 | 16'($urandom & 32'h1FFF), d);
          chk("R2 random ram bank", int'(ram_bank_o), m_ram);
        end
        2: begin
          case (m_idx)
            0, 1: d = $urandom_range(0, 59);
            2: d = $urandom_range(0, 23);
            3: d = $urandom_range(0, 255);
            default: d = ($urandom_range(0, 1) << 7) | (($urandom_range(0, 3) == 0) ? 64 : 0)
                         | $urandom_range(0, 1);
          endcase
          win_wr(d);
        end
        3: ticks($urandom_range(1, 2 * TPS));
        4: bus_wr(16'h6000 | 16'($urandom & 32'h1FFF), $urandom_range(0, 2));
        default: begin
          if (m_csel == 1) rd_chk("R10 random read");
          else ramcs_probe("R2 random ram access");
        end
      endcase
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule